// File: doc/BRIEF.md
# Link Quality Threshold Register File

This block is a single 16-bit management register that gives software indirect access to ten hidden threshold slots of a receive link quality monitor. There is one low and one high threshold for each of five adapted receiver parameters: equalizer coefficient, gain, baseline wander, frequency offset and frequency control. A three-bit parameter code and a one-bit low/high select in the register word choose the slot. A self-clearing strobe bit writes the data byte into that slot.

The same word also holds a sample bit. Writing it as 1 captures the currently selected live parameter value into a holding register, and while the bit is set the low byte of the read data shows that snapshot instead of the stored threshold. All ten thresholds are driven out in parallel to the comparison logic of the monitor. The comparison logic itself sits outside this block. Threshold writes are refused while the power-down input is high.

Top module: `lq_thresh_regs`

## Requirements
- R1: After reset, the read word is 0 and all ten threshold outputs are 0.
- R2: Read bits 15:14 and bit 12 are always 0, whatever was written to them.
- R3: A write with bit 12 set stores bits 7:0 into the slot chosen by parameter code bits 11:9 (0 equalizer coefficient, 1 gain, 2 baseline wander, 3 frequency offset, 4 frequency control) and by bit 8 (0 low, 1 high). For parameter p the slot appears on byte p of `thr_lo_out` or `thr_hi_out`.
- R4: A write with bit 12 clear leaves every threshold unchanged.
- R5: While the stored sample bit 13 is 0, read bits 7:0 return the threshold in the slot selected by the stored bits 11:8.
- R6: While `pwr_down` is 1, a write with bit 12 set changes no threshold. The select and sample fields are still stored.
- R7: Parameter codes 5 to 7 address no slot. Strobed writes with these codes change no threshold, and reads with the sample bit 0 return 0 in bits 7:0.
- R8: A write with bit 13 set captures byte p of `live_in`, where p is the written parameter code (0 for codes 5 to 7). While bit 13 stays set, read bits 7:0 return that snapshot, and the snapshot holds when `live_in` changes.
- R9: Writing again with bit 13 set takes a fresh capture.
- R10: A write with both bit 12 and bit 13 set performs the threshold write and also stores the sample bit as 1.
- R11: Read bits 13 and 11:8 return the values most recently written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_down | input | 1 | Blocks threshold writes while high |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| live_in | input | NPARAM*DW | Live adapted parameter values, byte p = parameter p |
| thr_lo_out | output | NPARAM*DW | Low thresholds, byte p = parameter p |
| thr_hi_out | output | NPARAM*DW | High thresholds, byte p = parameter p |

## Verification
The bench writes every one of the ten slots with a distinct byte. A design that decoded the low/high bit or the parameter code wrongly would show the value on the wrong output byte or read back the wrong slot. The bench strobes writes under power-down and with the unused codes 5 to 7. A design that leaked either write would change a threshold output or return non-zero read data. It changes `live_in` after a capture and then captures again. A design that tracked the live value instead of holding it, or one that never re-sampled, would show the wrong snapshot. A combined strobe-and-sample write catches a design that lets one action suppress the other.

// File: rtl/lq_thresh_regs.sv
module lq_thresh_regs #(
  parameter int NPARAM = 5,
  parameter int DW     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pwr_down,
  input  logic                 reg_we,
  input  logic [15:0]          reg_wdata,
  output logic [15:0]          reg_rdata,
  input  logic [NPARAM*DW-1:0] live_in,
  output logic [NPARAM*DW-1:0] thr_lo_out,
  output logic [NPARAM*DW-1:0] thr_hi_out
);
  localparam int SELW = 3;

  logic            samp_q;
  logic [SELW-1:0] psel_q;
  logic            hsel_q;
  logic [DW-1:0]   snap_q;
  logic [DW-1:0]   live_pick;
  logic [DW-1:0]   thr_pick;
  logic [7:0]      rd_byte;
  logic            wr_thr;
  logic            unused_rsvd;

  wire [SELW-1:0] w_psel = reg_wdata[11:9];
  wire            w_hsel = reg_wdata[8];

  assign unused_rsvd = ^reg_wdata[15:14];
  assign wr_thr      = reg_we & reg_wdata[12] & ~pwr_down;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
      psel_q <= '0;
      hsel_q <= 1'b0;
    end else if (reg_we) begin
      samp_q <= reg_wdata[13];
      psel_q <= w_psel;
      hsel_q <= w_hsel;
    end
  end

  always_comb begin
    live_pick = '0;
    thr_pick  = '0;
    for (int p = 0; p < NPARAM; p++) begin
      if (w_psel == SELW'(p)) live_pick = live_in[p*DW +: DW];
      if (psel_q == SELW'(p))
        thr_pick = hsel_q ? thr_hi_out[p*DW +: DW] : thr_lo_out[p*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                         snap_q <= '0;
    else if (reg_we && reg_wdata[13])   snap_q <= live_pick;
  end

  for (genvar p = 0; p < NPARAM; p++) begin : g_slot
    logic [DW-1:0] lo_q, hi_q;
    wire hit = wr_thr && (w_psel == SELW'(p));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= '0;
      end else if (hit) begin
        if (w_hsel) hi_q <= reg_wdata[DW-1:0];
        else        lo_q <= reg_wdata[DW-1:0];
      end
    end
    assign thr_lo_out[p*DW +: DW] = lo_q;
    assign thr_hi_out[p*DW +: DW] = hi_q;
  end

  assign rd_byte   = 8'(samp_q ? snap_q : thr_pick);
  assign reg_rdata = {2'b00, samp_q, 1'b0, psel_q, hsel_q, rd_byte};
endmodule

module lq_thresh_regs_chk #(
  parameter int NPARAM = 5,
  parameter int DW     = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pwr_down,
  input logic                 reg_we,
  input logic [15:0]          reg_wdata,
  input logic [15:0]          reg_rdata,
  input logic [NPARAM*DW-1:0] thr_lo_out,
  input logic [NPARAM*DW-1:0] thr_hi_out
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[15:14] == 2'b00 && reg_rdata[12] == 1'b0); // R2

  AST_NOSTROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_wdata[12]) |=> $stable(thr_lo_out) && $stable(thr_hi_out)); // R4

  AST_PD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> $stable(thr_lo_out) && $stable(thr_hi_out)); // R6

  AST_BADSEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[11:9] > 3'd4 && !reg_rdata[13]) |-> reg_rdata[7:0] == 8'h00); // R7

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[13] && !reg_we) |=> $stable(reg_rdata[7:0])); // R8

  AST_SEL_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> reg_rdata[11:8] == $past(reg_wdata[11:8]) &&
               reg_rdata[13] == $past(reg_wdata[13])); // R11
endmodule

bind lq_thresh_regs lq_thresh_regs_chk #(.NPARAM(NPARAM), .DW(DW)) u_chk (.*);

// File: tb/tb_lq_thresh_regs.sv
module tb_lq_thresh_regs;
  localparam int NP = 5;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_down = 1'b0;
  logic reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [NP*DW-1:0] live_in = '0;
  logic [NP*DW-1:0] thr_lo_out, thr_hi_out;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [7:0] exp_lo [NP];
  logic [7:0] exp_hi [NP];

  always #10 clk = ~clk;

  lq_thresh_regs #(.NPARAM(NP), .DW(DW)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] w);
    @(negedge clk);
    reg_we = 1'b1;
    reg_wdata = w;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  function automatic logic [15:0] word(input bit samp, input bit strobe,
      input logic [2:0] p, input bit hi, input logic [7:0] d);
    return {2'b00, samp, strobe, p, hi, d};
  endfunction

  task automatic chk_thr(input string req);
    for (int p = 0; p < NP; p++) begin
      chk(req, thr_lo_out[p*DW +: DW], exp_lo[p]);
      chk(req, thr_hi_out[p*DW +: DW], exp_hi[p]);
    end
  endtask

  task automatic t_reset;
    chk("R1", reg_rdata, 16'h0000);
    chk("R1", thr_lo_out, '0);
    chk("R1", thr_hi_out, '0);
  endtask

  task automatic t_fill;
    for (int p = 0; p < NP; p++) begin
      for (int h = 0; h < 2; h++) begin
        logic [7:0] d = 8'(8'h10 * (p + 1) + h * 5 + 3);
        wr(word(0, 1, 3'(p), h[0], d) | 16'hC000);
        if (h == 1) exp_hi[p] = d; else exp_lo[p] = d;
        chk("R2", {reg_rdata[15:14], reg_rdata[12]}, 3'b000);
        chk("R11", reg_rdata[11:8], {3'(p), h[0]});
      end
    end
    chk_thr("R3");
    for (int p = 0; p < NP; p++) begin
      wr(word(0, 0, 3'(p), 1'b0, 8'hEE));
      chk("R5", reg_rdata[7:0], exp_lo[p]);
      wr(word(0, 0, 3'(p), 1'b1, 8'hEE));
      chk("R5", reg_rdata[7:0], exp_hi[p]);
    end
    chk_thr("R4");
  endtask

  task automatic t_pd;
    pwr_down = 1'b1;
    wr(word(1, 1, 3'd3, 1'b1, 8'h99));
    chk_thr("R6");
    chk("R6", {reg_rdata[13], reg_rdata[11:8]}, {1'b1, 3'd3, 1'b1});
    pwr_down = 1'b0;
    wr(word(0, 0, 3'd3, 1'b1, 8'h00));
    chk("R6", reg_rdata[7:0], exp_hi[3]);
  endtask

  task automatic t_badsel;
    for (int c = 5; c < 8; c++) begin
      wr(word(0, 1, 3'(c), 1'b0, 8'hA5));
      chk("R7", reg_rdata[7:0], 8'h00);
      wr(word(0, 1, 3'(c), 1'b1, 8'h5A));
      chk("R7", reg_rdata[7:0], 8'h00);
    end
    chk_thr("R7");
  endtask

  task automatic t_sample;
    for (int p = 0; p < NP; p++) live_in[p*DW +: DW] = 8'(8'hC1 + p * 7);
    wr(word(1, 0, 3'd2, 1'b0, 8'h00));
    chk("R8", reg_rdata[7:0], 8'(8'hC1 + 14));
    chk("R11", reg_rdata[13], 1'b1);
    live_in[2*DW +: DW] = 8'h3C;
    @(negedge clk);
    @(negedge clk);
    chk("R8", reg_rdata[7:0], 8'(8'hC1 + 14));
    wr(word(1, 0, 3'd2, 1'b0, 8'h00));
    chk("R9", reg_rdata[7:0], 8'h3C);
    wr(word(1, 0, 3'd4, 1'b1, 8'h00));
    chk("R9", reg_rdata[7:0], 8'(8'hC1 + 28));
    wr(word(1, 0, 3'd6, 1'b0, 8'h00));
    chk("R8", reg_rdata[7:0], 8'h00);
    wr(word(0, 0, 3'd0, 1'b0, 8'h00));
    chk("R5", reg_rdata[7:0], exp_lo[0]);
  endtask

  task automatic t_both;
    live_in[1*DW +: DW] = 8'h77;
    wr(word(1, 1, 3'd1, 1'b1, 8'h5A));
    exp_hi[1] = 8'h5A;
    chk("R10", reg_rdata[13], 1'b1);
    chk("R10", reg_rdata[7:0], 8'h77);
    chk_thr("R10");
    wr(word(0, 0, 3'd1, 1'b1, 8'h00));
    chk("R10", reg_rdata[7:0], 8'h5A);
  endtask

  initial begin
    for (int p = 0; p < NP; p++) begin exp_lo[p] = '0; exp_hi[p] = '0; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_pd();
    t_badsel();
    t_sample();
    t_both();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule